// File: doc/BRIEF.md
# Multicast Spike Packet Router

This block is the per-node router of a triangular-mesh neuromorphic network that carries spikes as address events. A packet holds nothing but the identifier of the neuron that fired; the spike's time is the moment the packet arrives. The router gathers packets from six neighbour links and from two merge streams that collect the node's local cores. A round-robin arbiter passes one packet per cycle into a shared lookup.

The lookup is a small ternary match table. Each entry holds a key, a care mask and a 24-bit route word. Bits 5:0 of the route word pick external links and bits 23:6 pick local cores. The packet is copied to every output the word selects, all in the same cycle. When no entry matches, a packet that came in on a link goes out on the opposite link. This way, table entries are needed only where a route turns or delivers. A miss on a packet from a local merge stream has no opposite link, so the packet is dropped and the miss is recorded.

Every data input and output is valid/ready. A packet's data must stay stable while valid is high and ready is low. Each output holds one packet in a register and keeps it until the consumer takes it. An input is granted only when every output it selects can take a copy in that cycle. Back-pressure on any one selected output therefore stalls the whole packet. The table write port and the miss indicators are plain signals.

Top module: `spike_mcast_router`

## Requirements
- R1: After reset, every out_valid bit, every in_ready bit, miss_flag and miss_count are 0, and all table entries are invalid.
- R2: An identifier matches a valid entry when it equals the key on every bit where the entry's mask is 1; mask bits of 0 are don't-care. An entry written with its valid bit 0 never matches.
- R3: When several valid entries match, the entry with the lowest index supplies the route word.
- R4: Input index 0..5 are links E, NE, N, W, SW, S; index 6 and 7 are the two core merge streams. Output index j equals route-word bit j: outputs 0..5 are links E, NE, N, W, SW, S and output 6+c is core c. A packet accepted at a clock edge shows its identifier on every selected output, with out_valid high, right after that edge.
- R5: On a table miss, a packet that arrived on link i is sent only to link (i+3) mod 6, which is the opposite link.
- R6: On a table miss, a packet from a merge stream is accepted and dropped. miss_flag is set right after that edge and stays set until reset. miss_count rises by one per such drop and saturates at its maximum value.
- R7: A packet is accepted only in a cycle in which every output it selects is empty or is being read. Until then no copy appears on any output.
- R8: At most one in_ready bit is high in a cycle. After input i is accepted, the next grant goes to the first valid input after i in cyclic index order. After reset the search starts at input 0.
- R9: While out_valid is high and out_ready is low, that output's valid and identifier hold steady.
- R10: A table write at a clock edge governs lookups from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Per-input packet valid (6 links, 2 merge streams) |
| in_id | input | 128 | Per-input identifier, input k at bits 16k+15:16k |
| in_ready | output | 8 | Per-input accept, high in the cycle a packet is taken |
| out_valid | output | 24 | Per-output copy valid (6 links, 18 cores) |
| out_id | output | 384 | Per-output identifier, output j at bits 16j+15:16j |
| out_ready | input | 24 | Per-output consumer ready |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Entry index to write |
| tbl_ent_valid | input | 1 | Valid bit stored with the entry |
| tbl_key | input | 16 | Match key |
| tbl_mask | input | 16 | Care mask, 1 = compare this bit |
| tbl_route | input | 24 | Route word, one bit per output |
| miss_flag | output | 1 | Sticky: a merge-stream packet missed the table |
| miss_count | output | 8 | Saturating count of dropped merge-stream misses |

## Verification
in_ready is combinational. It is valid in the same cycle as the request, and the packet moves at the next rising edge. The copies, miss_flag and miss_count change one edge after acceptance, and a table write counts from the cycle after its edge. The bench drives at the falling edge and reads in_ready a fraction later. It queues the expected copies per output at that moment. It compares them at a later falling edge, at which the design has passed that rising edge. Stalls and arbitration order are checked cycle by cycle at the same falling-edge sample point.

// File: rtl/spk_rtr_pkg.sv
package spk_rtr_pkg;
  // Triangular mesh: six neighbour links, fixed by the topology.
  localparam int NLINK = 6;
  localparam int LIDX_W = 3;

  typedef enum logic [LIDX_W-1:0] {
    LNK_E  = 3'd0,
    LNK_NE = 3'd1,
    LNK_N  = 3'd2,
    LNK_W  = 3'd3,
    LNK_SW = 3'd4,
    LNK_S  = 3'd5
  } link_e;

  // Counterclockwise numbering puts the opposite link three steps away.
  function automatic logic [LIDX_W-1:0] opposite_link(input logic [LIDX_W-1:0] l);
    return (l >= 3'd3) ? l - 3'd3 : l + 3'd3;
  endfunction
endpackage

// File: rtl/spk_rr_arb.sv
module spk_rr_arb #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int p;
      p = (int'(last_q) + k) % N;
      if (!any && req[p]) begin
        any     = 1'b1;
        gnt[p]  = 1'b1;
        gnt_idx = IW'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= IW'(N - 1);
    else if (adv) last_q <= gnt_idx;
  end

  // R8
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/spk_tcam.sv
module spk_tcam #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  parameter int RW      = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] waddr,
  input  logic                       wvalid,
  input  logic [KEY_W-1:0]           wkey,
  input  logic [KEY_W-1:0]           wmask,
  input  logic [RW-1:0]              wroute,
  input  logic [KEY_W-1:0]           lkey,
  output logic                       hit,
  output logic [RW-1:0]              route
);
  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q  [ENTRIES];
  logic [KEY_W-1:0]   mask_q [ENTRIES];
  logic [RW-1:0]      rt_q   [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n)  vld_q <= '0;
    else if (we) vld_q[waddr] <= wvalid;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      key_q[waddr]  <= wkey;
      mask_q[waddr] <= wmask;
      rt_q[waddr]   <= wroute;
    end
  end

  // Scan from the top so the lowest matching index is the last to write.
  always_comb begin
    hit   = 1'b0;
    route = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (vld_q[e] && ((lkey ^ key_q[e]) & mask_q[e]) == '0) begin
        hit   = 1'b1;
        route = rt_q[e];
      end
    end
  end

  // R2
  empty_table_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q == '0) |-> !hit);
endmodule

// File: rtl/spk_out_slot.sv
module spk_out_slot #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] id_in,
  input  logic            out_rdy,
  output logic            out_vld,
  output logic [ID_W-1:0] out_id,
  output logic            free
);
  always_ff @(posedge clk) begin
    if (!rst_n)       out_vld <= 1'b0;
    else if (load)    out_vld <= 1'b1;
    else if (out_rdy) out_vld <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) out_id <= id_in;
  end

  assign free = !out_vld || out_rdy;

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_id)));

  // R7
  load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_vld || out_rdy));
endmodule

// File: rtl/spike_mcast_router.sv
module spike_mcast_router
  import spk_rtr_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int N_CORE  = 18,
  parameter int N_MERGE = 2,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 8,
  localparam int NIN    = NLINK + N_MERGE,
  localparam int NOUT   = NLINK + N_CORE,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       in_valid,
  input  logic [NIN*ID_W-1:0]  in_id,
  output logic [NIN-1:0]       in_ready,
  output logic [NOUT-1:0]      out_valid,
  output logic [NOUT*ID_W-1:0] out_id,
  input  logic [NOUT-1:0]      out_ready,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic                 tbl_ent_valid,
  input  logic [ID_W-1:0]      tbl_key,
  input  logic [ID_W-1:0]      tbl_mask,
  input  logic [NOUT-1:0]      tbl_route,
  output logic                 miss_flag,
  output logic [CNT_W-1:0]     miss_count
);
  localparam int IDX_W = $clog2(NIN);

  logic [NIN-1:0]    gnt;
  logic [IDX_W-1:0]  gnt_idx;
  logic              any_req;
  logic              accept;
  logic [ID_W-1:0]   sel_id;
  logic              tbl_hit;
  logic [NOUT-1:0]   tbl_rt;
  logic              src_is_link;
  logic [NLINK-1:0]  miss_link_oh;
  logic [NOUT-1:0]   dest;
  logic [NOUT-1:0]   slot_free;
  logic              all_free;
  logic              core_miss;

  spk_rr_arb #(.N(NIN)) arb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (in_valid),
    .adv     (accept),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any_req)
  );

  assign sel_id = in_id[gnt_idx*ID_W +: ID_W];

  spk_tcam #(.ENTRIES(ENTRIES), .KEY_W(ID_W), .RW(NOUT)) tcam_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .waddr  (tbl_addr),
    .wvalid (tbl_ent_valid),
    .wkey   (tbl_key),
    .wmask  (tbl_mask),
    .wroute (tbl_route),
    .lkey   (sel_id),
    .hit    (tbl_hit),
    .route  (tbl_rt)
  );

  assign src_is_link = (gnt_idx < IDX_W'(NLINK));

  always_comb begin
    miss_link_oh = '0;
    if (src_is_link) miss_link_oh[opposite_link(gnt_idx[LIDX_W-1:0])] = 1'b1;
  end

  assign dest      = tbl_hit ? tbl_rt : {{N_CORE{1'b0}}, miss_link_oh};
  assign core_miss = any_req && !tbl_hit && !src_is_link;
  assign all_free  = &(~dest | slot_free);
  assign accept    = any_req && all_free;
  assign in_ready  = accept ? gnt : '0;

  for (genvar j = 0; j < NOUT; j++) begin : g_slot
    spk_out_slot #(.ID_W(ID_W)) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept && dest[j]),
      .id_in   (sel_id),
      .out_rdy (out_ready[j]),
      .out_vld (out_valid[j]),
      .out_id  (out_id[j*ID_W +: ID_W]),
      .free    (slot_free[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_flag  <= 1'b0;
      miss_count <= '0;
    end else if (accept && core_miss) begin
      miss_flag <= 1'b1;
      if (miss_count != '1) miss_count <= miss_count + 1'b1;
    end
  end

  // R6
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_flag |=> miss_flag);

  // R8
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready) && ((in_ready & ~in_valid) == '0));

  // R5
  default_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tbl_hit && src_is_link) |=>
      ((out_valid[NLINK-1:0] & $past(miss_link_oh)) == $past(miss_link_oh)));
endmodule

// File: tb/spike_mcast_router_tb_top.sv
`timescale 1ns/100ps
module spike_mcast_router_tb_top;
  localparam int ID_W = 16;
  localparam int NIN  = 8;
  localparam int NOUT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              vld_a [NIN];
  logic [ID_W-1:0]   id_a  [NIN];
  logic [NIN-1:0]    in_valid;
  logic [NIN*ID_W-1:0] in_id;
  logic [NIN-1:0]    in_ready;
  logic [NOUT-1:0]   out_valid;
  logic [NOUT*ID_W-1:0] out_id;
  logic [NOUT-1:0]   out_ready;
  logic [NOUT-1:0]   rdy_man;
  logic [NOUT-1:0]   lfsr;
  logic              bp_mode = 1'b0;
  logic              tbl_we = 1'b0;
  logic [3:0]        tbl_addr = '0;
  logic              tbl_ent_valid = 1'b0;
  logic [ID_W-1:0]   tbl_key = '0, tbl_mask = '0;
  logic [NOUT-1:0]   tbl_route = '0;
  logic              miss_flag;
  logic [7:0]        miss_count;

  for (genvar k = 0; k < NIN; k++) begin : g_in
    assign in_valid[k] = vld_a[k];
    assign in_id[k*ID_W +: ID_W] = id_a[k];
  end
  assign out_ready = bp_mode ? lfsr : rdy_man;

  spike_mcast_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_id(in_id), .in_ready(in_ready),
    .out_valid(out_valid), .out_id(out_id), .out_ready(out_ready),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_ent_valid(tbl_ent_valid),
    .tbl_key(tbl_key), .tbl_mask(tbl_mask), .tbl_route(tbl_route),
    .miss_flag(miss_flag), .miss_count(miss_count)
  );

  int n_chk = 0, n_fail = 0, exp_miss = 0, n_acc = 0;
  int acc_order [64];
  bit run_mon = 1'b0, done = 1'b0;
  logic [ID_W-1:0] exp_q [NOUT][$];
  logic              m_vld [16];
  logic [ID_W-1:0]   m_key [16];
  logic [ID_W-1:0]   m_msk [16];
  logic [NOUT-1:0]   m_rt  [16];
  logic              prev_stall [NOUT];
  logic [ID_W-1:0]   prev_id    [NOUT];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) lfsr <= {lfsr[NOUT-2:0], lfsr[NOUT-1] ^ lfsr[NOUT-4] ^ lfsr[0]};

  // Model from R2..R6: lowest valid match, else opposite link, else drop (bit 24).
  function automatic logic [24:0] model(input int src, input logic [ID_W-1:0] id);
    for (int e = 0; e < 16; e++)
      if (m_vld[e] && ((id ^ m_key[e]) & m_msk[e]) == '0) return {1'b0, m_rt[e]};
    if (src < 6) return 25'(1) << ((src + 3) % 6);
    return {1'b1, 24'h0};
  endfunction

  task automatic wr(input int a, input bit v, input logic [15:0] k, input logic [15:0] m, input logic [23:0] r);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(a); tbl_ent_valid = v;
    tbl_key = k; tbl_mask = m; tbl_route = r;
    @(posedge clk); #0.5;
    tbl_we = 1'b0;
    m_vld[a] = v; m_key[a] = k; m_msk[a] = m; m_rt[a] = r;
  endtask

  task automatic send(input int src, input logic [ID_W-1:0] id);
    logic [24:0] r;
    int guard;
    @(negedge clk);
    vld_a[src] = 1'b1; id_a[src] = id;
    #0.5;
    guard = 0;
    while (!in_ready[src] && guard < 300) begin
      @(negedge clk); #0.5; guard++;
    end
    chk(in_ready[src], "R8 input granted", 32'(in_ready[src]), 1);
    r = model(src, id);
    if (r[24]) exp_miss++;
    else for (int j = 0; j < NOUT; j++) if (r[j]) exp_q[j].push_back(id);
    acc_order[n_acc] = src; n_acc++;
    @(posedge clk); #0.5;
    vld_a[src] = 1'b0;
  endtask

  // Monitor: pops one expectation per output handshake; R4/R9.
  always begin
    @(negedge clk); #1;
    if (run_mon) begin
      for (int j = 0; j < NOUT; j++) begin
        if (prev_stall[j])
          chk(out_valid[j] && out_id[j*ID_W +: ID_W] == prev_id[j], "R9 hold under stall",
              32'(out_id[j*ID_W +: ID_W]), 32'(prev_id[j]));
        if (out_valid[j] && out_ready[j]) begin
          if (exp_q[j].size() == 0) chk(1'b0, "R4 unexpected copy", 32'(j), 32'hFFFF);
          else begin
            logic [ID_W-1:0] e;
            e = exp_q[j].pop_front();
            chk(out_id[j*ID_W +: ID_W] == e, "R4 copy id", 32'(out_id[j*ID_W +: ID_W]), 32'(e));
          end
        end
        prev_stall[j] = out_valid[j] && !out_ready[j];
        prev_id[j]    = out_id[j*ID_W +: ID_W];
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NIN; k++) begin vld_a[k] = 1'b0; id_a[k] = '0; end
    for (int e = 0; e < 16; e++) begin m_vld[e] = 1'b0; m_key[e] = '0; m_msk[e] = '0; m_rt[e] = '0; end
    for (int j = 0; j < NOUT; j++) begin prev_stall[j] = 1'b0; prev_id[j] = '0; end
    rdy_man = '1;
    lfsr = 24'hA5C3E1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1
    chk(out_valid == '0, "R1 out_valid reset", 32'(out_valid), 0);
    chk(in_ready == '0, "R1 in_ready reset", 32'(in_ready), 0);
    chk({miss_flag, miss_count} == '0, "R1 miss state reset", 32'({miss_flag, miss_count}), 0);
    run_mon = 1'b1;

    // R1: table empty -> link miss goes straight through (E -> W)
    send(0, 16'h0A05);
    // Table: R2 masked keys, R3 overlap, invalid entry
    wr(0, 1, 16'h0A00, 16'hFFF0, 24'h800041);   // E, core0, core17
    wr(1, 1, 16'h0600, 16'hFFFF, 24'h000408);   // W, core4
    wr(2, 1, 16'h0100, 16'hFF00, 24'h000084);   // N, core1
    wr(5, 1, 16'h0123, 16'hFFFF, 24'h000100);   // core2
    wr(7, 0, 16'h0555, 16'hFFFF, 24'h000800);   // never matches
    // R2: masked match from a merge stream and from a link
    send(6, 16'h0A05);
    send(1, 16'h0A0F);
    // R3: entries 2 and 5 both match, entry 2 wins
    send(3, 16'h0123);
    // R2: invalid entry -> miss, N -> S; masked bits differ -> miss, SW -> NE
    send(2, 16'h0555);
    send(4, 16'h0B00);
    // R5: every link's opposite
    for (int s = 0; s < 6; s++) send(s, 16'h3000 + 16'(s));
    // R6: merge-stream misses
    send(7, 16'h7777);
    @(negedge clk); #0.5;
    chk(miss_flag == 1'b1, "R6 miss flag set", 32'(miss_flag), 1);
    chk(miss_count == 8'(exp_miss), "R6 miss count", 32'(miss_count), 32'(exp_miss));
    send(6, 16'h7778);
    @(negedge clk); #0.5;
    chk(miss_count == 8'(exp_miss), "R6 miss count second", 32'(miss_count), 32'(exp_miss));
    chk(miss_flag == 1'b1, "R6 miss flag sticky", 32'(miss_flag), 1);

    // R10: miss before the write, hit right after it
    send(0, 16'h4444);
    wr(9, 1, 16'h4444, 16'hFFFF, 24'h008000);
    send(0, 16'h4444);

    // R8: round robin order
    send(7, 16'h0A01);
    n_acc = 0;
    fork
      send(0, 16'h3100);
      send(2, 16'h3102);
      send(5, 16'h3105);
    join
    chk(acc_order[0] == 0 && acc_order[1] == 2 && acc_order[2] == 5, "R8 order after 7",
        32'({acc_order[0][3:0], acc_order[1][3:0], acc_order[2][3:0]}), 32'h025);
    n_acc = 0;
    fork
      send(1, 16'h3201);
      send(4, 16'h3204);
      send(6, 16'h0A02);
    join
    chk(acc_order[0] == 6 && acc_order[1] == 1 && acc_order[2] == 4, "R8 order after 5",
        32'({acc_order[0][3:0], acc_order[1][3:0], acc_order[2][3:0]}), 32'h614);

    // R7: W output stalled and full, packet needing W and core4 must wait
    @(negedge clk); rdy_man[3] = 1'b0;
    send(0, 16'h5000);
    @(negedge clk);
    vld_a[1] = 1'b1; id_a[1] = 16'h0600;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #0.5;
      chk(in_ready[1] == 1'b0, "R7 held while W full", 32'(in_ready[1]), 0);
      chk(out_valid[10] == 1'b0, "R7 no partial copy", 32'(out_valid[10]), 0);
    end
    @(negedge clk); rdy_man[3] = 1'b1; #0.5;
    chk(in_ready[1] == 1'b1, "R7 accepted on drain", 32'(in_ready[1]), 1);
    exp_q[3].push_back(16'h0600); exp_q[10].push_back(16'h0600);
    @(posedge clk); #0.5; vld_a[1] = 1'b0;

    // R9/R4: burst under pseudo-random back-pressure
    @(negedge clk); bp_mode = 1'b1;
    for (int b = 0; b < 40; b++) begin
      logic [15:0] ids [4];
      ids[0] = 16'h0A00 + 16'(b % 16); ids[1] = 16'h0600;
      ids[2] = 16'h0100 + 16'(b);      ids[3] = 16'h6000 + 16'(b);
      send(b % 8, ids[b % 4]);
    end
    @(negedge clk); bp_mode = 1'b0;
    repeat (10) @(negedge clk);
    begin
      int left;
      left = 0;
      for (int j = 0; j < NOUT; j++) left += exp_q[j].size();
      chk(left == 0, "R4 all copies delivered", 32'(left), 0);
    end
    #0.5;
    chk(miss_count == 8'(exp_miss), "R6 final miss count", 32'(miss_count), 32'(exp_miss));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule